// File: doc/BRIEF.md
# Triggered Capture Sequencer

This block runs one sample capture at a time under the control of an 8-bit host register. A host write with the start bit set begins filling an external sample buffer at once. Alternatively, the host places the start pattern in the upper nibble of the register, and the next synchronized rising edge of a trigger input shifts the register right by four bits. That shift brings the pattern down into place and starts the capture.

Once started, the block latches the requested depth. It writes exactly that many valid samples into the buffer, then reads them back and sends each sample out as bytes on a ready/valid stream. When the stream accepts the final byte, the register clears itself. Bit 1 of the register drives an activity LED, so the LED stays lit from the start of the capture until the self-clear.

Trigger edges that arrive while the register holds zero shift in zeros and have no effect. A free-running trigger therefore starts only one capture for each arming.

Top module: `trig_capture_top`

## Requirements
- R1: A host write of 8'h03 starts a capture. Samples presented from the second rising clock edge after the write edge onward are written to the buffer.
- R2: `led_o` always equals bit 1 of the control register, so it is 1 during a capture started with 8'h03 and 0 once the register has cleared.
- R3: A capture writes exactly the latched number of samples to buffer addresses 0, 1, 2 … in order. No buffer write happens in a cycle that also has a buffer read or a byte on the output.
- R4: Each 16-bit sample leaves as two bytes, bits [7:0] first and bits [15:8] second. A byte transfers only on a cycle with both `tx_valid_o` and `tx_ready_i` high, and `tx_data_o` holds steady while `tx_ready_i` is low.
- R5: On the clock edge that transfers the final byte, the control register becomes 8'h00, which turns the LED off.
- R6: A trigger rising edge replaces the register value v with v >> 4 (for example 8'h30 becomes 8'h03 and starts a capture, and 8'hA0 becomes 8'h0A). While bit 0 is 0, no sample is written.
- R7: A trigger edge while the register is 8'h00 leaves it at 8'h00. Repeated trigger pulses after a capture has finished start no new capture.
- R8: The trigger goes through a two-stage synchronizer and a rising-edge detector. A trigger held high causes exactly one shift, applied on the third rising clock edge at which the input is sampled high.
- R9: A host write in the same cycle as a trigger shift wins: the register takes the written value.
- R10: The 16-bit depth is latched when the capture starts, and later changes of `depth_i` do not alter that capture. A start with depth 0 writes nothing and clears the register on the same edge.
- R11: While a capture is filling or draining, trigger edges do not change the register or the byte stream.
- R12: A sample is written only in cycles where `smp_valid_i` is high. Cycles without it do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_wdata_i | input | 8 | Host register write value |
| depth_i | input | 16 | Requested number of samples |
| trig_i | input | 1 | External trigger, asynchronous |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_data_i | input | 16 | Sample value |
| buf_we_o | output | 1 | Buffer write enable |
| buf_waddr_o | output | 16 | Buffer write address |
| buf_wdata_o | output | 16 | Buffer write data |
| buf_re_o | output | 1 | Buffer read request; data expected on the next cycle |
| buf_raddr_o | output | 16 | Buffer read address |
| buf_rdata_i | input | 16 | Buffer read data, one cycle after the request |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_ready_i | input | 1 | Serial side ready for a byte |
| led_o | output | 1 | Activity LED |
| ctrl_o | output | 8 | Control register value |

## Verification
- **Host write:** visible on `ctrl_o` one edge later. Filling starts on the edge after that.
- **Trigger:** a trigger driven high before edge P1 shifts the register at P3. The bench waits at least four edges before it reads `ctrl_o`, and it drives the collision write so that it lands on P3 exactly.
- **Stimulus timing:** samples are presented only from the second edge after the start.
- **Byte checks:** bytes are compared at the falling edge, before the edge that transfers them. The stream monitor drives ready and compares each transfer in that same half cycle against a scoreboard queue, which the sample driver fills with low and high bytes.
- **Self-clear:** checked once the queue has drained and the register has reached zero, with a bounded wait.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned NIB_SHIFT = 4;
  localparam int unsigned START_BIT = 0;
  localparam int unsigned LED_BIT   = 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_RD,
    ST_LAT,
    ST_TX
  } cap_state_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cap_ctrl_reg.sv
module cap_ctrl_reg
  import cap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              busy_i,
  output logic [CTRL_W-1:0] q_o
);
  logic [CTRL_W-1:0] q_q;
  logic              frozen;

  // a started capture is never disturbed by a trigger
  assign frozen = busy_i | q_q[START_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= '0;
    else if (we_i)              q_q <= wdata_i;
    else if (clr_i)             q_q <= '0;
    else if (shift_i && !frozen) q_q <= q_q >> NIB_SHIFT;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cap_engine.sv
module cap_engine
  import cap_pkg::*;
#(
  parameter int unsigned DEPTH_W = 16,
  parameter int unsigned SMP_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               smp_valid_i,
  input  logic [SMP_W-1:0]   smp_data_i,
  output logic               buf_we_o,
  output logic [DEPTH_W-1:0] buf_waddr_o,
  output logic [SMP_W-1:0]   buf_wdata_o,
  output logic               buf_re_o,
  output logic [DEPTH_W-1:0] buf_raddr_o,
  input  logic [SMP_W-1:0]   buf_rdata_i,
  output logic [7:0]         tx_data_o,
  output logic               tx_valid_o,
  input  logic               tx_ready_i,
  output logic               busy_o,
  output logic               clr_o
);
  localparam int unsigned BYTES  = SMP_W / 8;
  localparam int unsigned BSEL_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  cap_state_e         state_q;
  logic [DEPTH_W-1:0] cnt_q, depth_q;
  logic [SMP_W-1:0]   hold_q;
  logic [BSEL_W-1:0]  bsel_q;
  logic               last_smp, last_byte, empty_req;

  assign last_smp  = (cnt_q == depth_q - DEPTH_W'(1));
  assign last_byte = (bsel_q == BSEL_W'(BYTES - 1));
  assign empty_req = (depth_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      depth_q <= '0;
      hold_q  <= '0;
      bsel_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i && !empty_req) begin
          depth_q <= depth_i;
          cnt_q   <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (smp_valid_i) begin
          if (last_smp) begin
            cnt_q   <= '0;
            state_q <= ST_RD;
          end else begin
            cnt_q <= cnt_q + DEPTH_W'(1);
          end
        end
        ST_RD: state_q <= ST_LAT;
        ST_LAT: begin
          hold_q  <= buf_rdata_i;
          bsel_q  <= '0;
          state_q <= ST_TX;
        end
        ST_TX: if (tx_ready_i) begin
          if (last_byte) begin
            if (last_smp) state_q <= ST_IDLE;
            else begin
              cnt_q   <= cnt_q + DEPTH_W'(1);
              state_q <= ST_RD;
            end
          end else begin
            bsel_q <= bsel_q + BSEL_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign buf_we_o    = (state_q == ST_FILL) && smp_valid_i;
  assign buf_waddr_o = cnt_q;
  assign buf_wdata_o = smp_data_i;
  assign buf_re_o    = (state_q == ST_RD);
  assign buf_raddr_o = cnt_q;
  assign tx_valid_o  = (state_q == ST_TX);
  assign tx_data_o   = hold_q[{bsel_q, 3'b000} +: 8];
  assign busy_o      = (state_q != ST_IDLE);
  assign clr_o       = ((state_q == ST_IDLE) && start_i && empty_req) ||
                       ((state_q == ST_TX) && tx_ready_i && last_byte && last_smp);
endmodule

// File: rtl/trig_capture_top.sv
module trig_capture_top
  import cap_pkg::*;
#(
  parameter int unsigned DEPTH_W     = 16,
  parameter int unsigned SMP_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic [7:0]         host_wdata_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               trig_i,
  input  logic               smp_valid_i,
  input  logic [SMP_W-1:0]   smp_data_i,
  output logic               buf_we_o,
  output logic [DEPTH_W-1:0] buf_waddr_o,
  output logic [SMP_W-1:0]   buf_wdata_o,
  output logic               buf_re_o,
  output logic [DEPTH_W-1:0] buf_raddr_o,
  input  logic [SMP_W-1:0]   buf_rdata_i,
  output logic [7:0]         tx_data_o,
  output logic               tx_valid_o,
  input  logic               tx_ready_i,
  output logic               led_o,
  output logic [7:0]         ctrl_o
);
  logic              trig_rise, busy, clr;
  logic [CTRL_W-1:0] ctrl_q;

  trig_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(trig_i),
    .rise_o (trig_rise)
  );

  cap_ctrl_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (host_we_i),
    .wdata_i(host_wdata_i),
    .clr_i  (clr),
    .shift_i(trig_rise),
    .busy_i (busy),
    .q_o    (ctrl_q)
  );

  cap_engine #(.DEPTH_W(DEPTH_W), .SMP_W(SMP_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ctrl_q[START_BIT]),
    .depth_i    (depth_i),
    .smp_valid_i(smp_valid_i),
    .smp_data_i (smp_data_i),
    .buf_we_o   (buf_we_o),
    .buf_waddr_o(buf_waddr_o),
    .buf_wdata_o(buf_wdata_o),
    .buf_re_o   (buf_re_o),
    .buf_raddr_o(buf_raddr_o),
    .buf_rdata_i(buf_rdata_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .busy_o     (busy),
    .clr_o      (clr)
  );

  assign led_o  = ctrl_q[LED_BIT];
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_we_i,
  input logic       smp_valid_i,
  input logic       buf_we_o,
  input logic       buf_re_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic [7:0] ctrl_o
);
  AST_FILL_NOT_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> !buf_re_o && !tx_valid_o); // R3

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R4

  AST_ZERO_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o == 8'h00) && !host_we_i |=> ctrl_o == 8'h00); // R7

  AST_DRAIN_UNDISTURBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !host_we_i |=> (ctrl_o == $past(ctrl_o)) || (ctrl_o == 8'h00)); // R11

  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> smp_valid_i); // R12
endmodule

bind trig_capture_top trig_capture_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_we_i  (host_we_i),
  .smp_valid_i(smp_valid_i),
  .buf_we_o   (buf_we_o),
  .buf_re_o   (buf_re_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .ctrl_o     (ctrl_o)
);

// File: tb/tb_trig_capture_top.sv
module tb_trig_capture_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] depth = '0;
  logic        trig = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        buf_we, buf_re, tx_valid, led;
  logic [15:0] buf_waddr, buf_wdata, buf_raddr;
  logic [15:0] buf_rdata = '0;
  logic [7:0]  tx_data, ctrl;
  logic        tx_ready = 1'b0;

  int errors = 0;
  int checks = 0;
  int wr_count = 0;
  int byte_count = 0;
  int overlap = 0;
  int order_err = 0;
  int next_waddr = 0;
  int rdy_phase = 0;
  logic [7:0]  exp_q[$];
  logic [15:0] mem [0:255];

  always #2 clk = ~clk;

  trig_capture_top dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_wdata_i(host_wdata),
    .depth_i(depth), .trig_i(trig), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .buf_we_o(buf_we), .buf_waddr_o(buf_waddr), .buf_wdata_o(buf_wdata),
    .buf_re_o(buf_re), .buf_raddr_o(buf_raddr), .buf_rdata_i(buf_rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .led_o(led), .ctrl_o(ctrl)
  );

  // buffer model, one-cycle read latency
  always @(posedge clk) begin
    if (buf_we) mem[buf_waddr[7:0]] <= buf_wdata;
    if (buf_re) buf_rdata <= mem[buf_raddr[7:0]];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: drives ready, scores bytes and writes before the edge that takes them
  always @(negedge clk) begin
    if (rst_n) begin
      rdy_phase = rdy_phase + 1;
      tx_ready = (rdy_phase % 3) != 0;
      if (buf_we) begin
        wr_count++;
        if (int'(buf_waddr) != next_waddr) order_err++;
        next_waddr++;
        if (buf_re || tx_valid) overlap++;
      end
      if (tx_valid && tx_ready) begin
        byte_count++;
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", int'(tx_data), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e, "R4 byte order/value", int'(tx_data), int'(e));
        end
      end
    end
  end

  task automatic host_write(input logic [7:0] v);
    @(negedge clk); host_we = 1'b1; host_wdata = v;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic trig_pulse();
    @(negedge clk); trig = 1'b1;
    repeat (2) @(negedge clk);
    trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // driver: presents n accepted samples with gaps, then extras that must be dropped
  task automatic drive_samples(input int n, input int extra);
    for (int i = 0; i < n + extra; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data = 16'($urandom);
      if (i < n) begin
        exp_q.push_back(smp_data[7:0]);
        exp_q.push_back(smp_data[15:8]);
      end
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (i % 3) @(negedge clk);
    end
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while ((exp_q.size() != 0 || ctrl != 8'h00) && t < 5000) begin
      @(negedge clk); t++;
    end
    chk(t < 5000, tag, t, 0);
  endtask

  task automatic begin_capture_counts();
    wr_count = 0; next_waddr = 0; byte_count = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl == 8'h00 && !led && !tx_valid && !buf_we, "reset state", int'(ctrl), 0);

    // R1 R2 R3 R4 R5 R12: immediate capture of 8 samples
    depth = 16'd8;
    begin_capture_counts();
    host_write(8'h03);
    chk(ctrl == 8'h03, "R1 register after write", int'(ctrl), 8'h03);
    chk(led == 1'b1, "R2 led lit during capture", int'(led), 1);
    drive_samples(8, 3);
    wait_done("R5 capture finished and cleared");
    chk(wr_count == 8, "R3 write count", wr_count, 8);
    chk(order_err == 0, "R3 address order", order_err, 0);
    chk(overlap == 0, "R3 fill/drain overlap", overlap, 0);
    chk(byte_count == 16, "R4 byte count", byte_count, 16);
    chk(ctrl == 8'h00 && led == 1'b0, "R5 self-clear and led off", int'(ctrl), 0);

    // R6 R11: armed pattern and trigger
    depth = 16'd6;
    begin_capture_counts();
    host_write(8'h30);
    repeat (3) begin
      @(negedge clk); smp_valid = 1'b1; smp_data = 16'h1234;
    end
    @(negedge clk); smp_valid = 1'b0;
    chk(wr_count == 0, "R6 armed writes nothing", wr_count, 0);
    chk(ctrl == 8'h30 && !led, "R6 armed value held", int'(ctrl), 8'h30);
    trig_pulse();
    chk(ctrl == 8'h03, "R6 trigger shifts 30->03", int'(ctrl), 8'h03);
    drive_samples(3, 0);
    trig_pulse();
    chk(ctrl == 8'h03, "R11 trigger during fill ignored", int'(ctrl), 8'h03);
    drive_samples(3, 2);
    repeat (6) @(negedge clk);
    trig_pulse();
    chk(ctrl == 8'h03 || ctrl == 8'h00, "R11 trigger during drain ignored", int'(ctrl), 8'h03);
    wait_done("R6 triggered capture finished");
    chk(wr_count == 6 && byte_count == 12, "R6 triggered capture size", wr_count, 6);

    // R7: free-running trigger while zero
    begin_capture_counts();
    repeat (4) trig_pulse();
    chk(ctrl == 8'h00, "R7 zero stays zero", int'(ctrl), 0);
    chk(wr_count == 0 && byte_count == 0, "R7 no new capture", wr_count, 0);

    // R6 R2: other nibble values
    host_write(8'hA0);
    trig_pulse();
    chk(ctrl == 8'h0A && led == 1'b1, "R6 A0->0A and R2 led", int'(ctrl), 8'h0A);
    trig_pulse();
    chk(ctrl == 8'h00 && led == 1'b0, "R6 0A->00", int'(ctrl), 0);

    // R8: level-high trigger shifts once, on the third edge
    host_write(8'hC0);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(ctrl == 8'hC0, "R8 no shift before third edge", int'(ctrl), 8'hC0);
    @(negedge clk);
    chk(ctrl == 8'h0C, "R8 shift on third edge", int'(ctrl), 8'h0C);
    repeat (10) @(negedge clk);
    chk(ctrl == 8'h0C, "R8 held level shifts once", int'(ctrl), 8'h0C);
    trig = 1'b0;
    host_write(8'h00);

    // R9: host write collides with shift
    begin_capture_counts();
    host_write(8'h30);
    trig = 1'b1;
    @(negedge clk); @(negedge clk);
    host_we = 1'b1; host_wdata = 8'h80;
    @(negedge clk);
    host_we = 1'b0; trig = 1'b0;
    repeat (4) @(negedge clk);
    chk(ctrl == 8'h80 && wr_count == 0, "R9 host write wins", int'(ctrl), 8'h80);
    trig_pulse();
    chk(ctrl == 8'h08, "R9 later trigger still shifts", int'(ctrl), 8'h08);
    host_write(8'h00);

    // R10: depth zero
    begin_capture_counts();
    depth = 16'd0;
    host_write(8'h03);
    @(negedge clk);
    chk(ctrl == 8'h00 && wr_count == 0, "R10 depth zero clears", int'(ctrl), 0);

    // R10: depth latched at start
    begin_capture_counts();
    depth = 16'd5;
    host_write(8'h03);
    @(negedge clk);
    depth = 16'd20;
    drive_samples(5, 4);
    wait_done("R10 latched-depth capture finished");
    chk(wr_count == 5 && byte_count == 10, "R10 depth latched", wr_count, 5);

    // R3: depth of one
    begin_capture_counts();
    depth = 16'd1;
    host_write(8'h03);
    @(negedge clk);
    drive_samples(1, 2);
    wait_done("R3 single-sample capture finished");
    chk(wr_count == 1 && byte_count == 2, "R3 single sample", wr_count, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule